// File: doc/BRIEF.md
# Interval Timer Bus Register Interface

This block is the processor-facing register front end of a three-channel interval timer. The bus is a 2-bit address, one write strobe, one read strobe and 8-bit data in each direction. Addresses 0 to 2 reach the 16-bit count of channels 0 to 2 one byte at a time. Address 3 takes control words, which configure a channel, freeze its count for reading, or ask several channels at once to capture their count and a status byte.

Toward each channel the block presents the configured counting mode and BCD flag. When a count is completely written, it gives a one-cycle load pulse together with the 16-bit count. It takes in each channel's live count and output level, which it uses for latches, status bytes and unlatched reads. The counting itself lives in the channels, outside this block.

Read data is combinational. It is valid while the read strobe is high, and the read's side effects take place at the clock edge that ends the access.

Top module: `tmr_bus_regs`

## Requirements
- R1: After reset, every channel has access mode 3 (word), counting mode 0 and BCD flag 0. No count or status latch is pending, the next data write is taken as a low byte, the next unlatched read returns the low byte, and no load pulse is raised.
- R2: A write to address 3 whose bits 7:6 name channel 0, 1 or 2 and whose bits 5:4 are nonzero sets that channel's access mode to bits 5:4, its counting mode to bits 3:1 and its BCD flag to bit 0. The new counting mode and BCD flag appear on `ch_mode` (3 bits per channel) and `ch_bcd` from the clock edge of the write onward.
- R3: A write that completes a count raises that channel's `ch_load` bit for exactly one cycle, starting at the clock edge of the write, with the count on that channel's 16-bit slice of `ch_count`. At most one `ch_load` bit is high in any cycle.
- R4: In access mode 1, each data write loads the count {8'h00, byte}. In access mode 2, each data write loads {byte, 8'h00}.
- R5: In access mode 3, the first data write is held and produces no load. The second write loads {second byte, first byte}, and the one after that is again taken as a low byte.
- R6: A control word with bits 5:4 equal to 0 latches the live count of the channel in bits 7:6. That channel's access mode, counting mode and BCD flag stay unchanged.
- R7: A control word with bits 7:6 equal to 3 is a read-back. Channel i is affected when bit i+1 is set. If bit 5 is clear, the channel's count is latched; if bit 4 is clear, its status is latched. The status byte is {output level, 1'b0, access mode[1:0], counting mode[2:0], BCD flag}.
- R8: A read returns a pending status byte first and clears it. A pending count latch then returns its low byte (access mode 1), its high byte (mode 2), or its low byte then its high byte (mode 3), and is cleared after the last byte.
- R9: A count latch request is ignored while a count latch of that channel is unread. A status latch request is ignored while a status latch of that channel is unread.
- R10: With nothing latched, a read returns the live low byte in access mode 1 and the live high byte in access mode 2. In access mode 3 it alternates between the live low byte and the live high byte, starting with the low byte.
- R11: A read of address 3 returns 0 and changes no state. `bus_rdata` is 0 while `bus_rd` is low.
- R12: A control word that configures a channel restarts that channel's write and read byte sequences, so the next write is a low byte and the next unlatched word read is a low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 2 | Register address: 0 to 2 channel data, 3 control |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| ch_live_cnt | input | 48 | Live count of each channel, 16 bits per channel, channel 0 lowest |
| ch_live_out | input | 3 | Output level of each channel |
| ch_load | output | 3 | One-cycle count load pulse per channel |
| ch_count | output | 48 | Count to load, 16 bits per channel |
| ch_mode | output | 9 | Counting mode per channel, 3 bits each |
| ch_bcd | output | 3 | BCD flag per channel |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle. Under that assumption, a latch request can never coincide with a read of the same channel, and a configuration write can never coincide with a latch of the same channel. Every bench access is a single-cycle strobe with at least one idle cycle after it, so this assumption always holds. The live counts and output levels change only between accesses, never while a strobe is active.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 16;
  localparam int MODE_W = 3;
  localparam int ADDR_W = 2;
  localparam int NCH_MAX = 3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    CL_NONE = 2'd0,
    CL_LO   = 2'd1,
    CL_HI   = 2'd2,
    CL_BOTH = 2'd3
  } cl_e;

  typedef struct packed {
    acc_e              acc;
    logic [MODE_W-1:0] mode;
    logic              bcd;
  } cfg_t;
endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
  import tmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output cfg_t              cfg_word,
  output logic [NCH-1:0]    cfg_we,
  output logic [NCH-1:0]    cnt_lat,
  output logic [NCH-1:0]    sts_lat,
  output logic [NCH-1:0]    dat_we,
  output logic [NCH-1:0]    dat_re
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NCH_MAX);
  localparam logic [1:0]        RB_SEL    = 2'(NCH_MAX);

  logic ctl_wr;
  logic is_rb;
  logic acc_zero;

  always_comb begin
    ctl_wr   = wr_en && (addr == CTRL_ADDR);
    is_rb    = (wdata[7:6] == RB_SEL);
    acc_zero = (wdata[5:4] == 2'b00);
    cfg_word = '{acc: acc_e'(wdata[5:4]), mode: wdata[3:1], bcd: wdata[0]};
  end

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    logic sel;
    logic rb_hit;
    always_comb begin
      sel        = (wdata[7:6] == 2'(i));
      rb_hit     = is_rb && wdata[i+1];
      cfg_we[i]  = ctl_wr && sel && !acc_zero;
      cnt_lat[i] = ctl_wr && ((sel && acc_zero) || (rb_hit && !wdata[5]));
      sts_lat[i] = ctl_wr && rb_hit && !wdata[4];
      dat_we[i]  = wr_en && (addr == ADDR_W'(i));
      dat_re[i]  = rd_en && !wr_en && (addr == ADDR_W'(i));
    end
  end
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  cfg_t              cfg_in,
  input  logic              cnt_lat,
  input  logic              sts_lat,
  input  logic              dat_we,
  input  logic              dat_re,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic              live_out,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              ld_stb,
  output logic [CNT_W-1:0]  ld_val,
  output logic [MODE_W-1:0] mode_o,
  output logic              bcd_o
);
  localparam int HI = CNT_W - 1;
  localparam int LO_TOP = BYTE_W - 1;

  cfg_t              cfg_q, cfg_d;
  logic              wr_hi_q, wr_hi_d;
  logic [BYTE_W-1:0] wr_lo_q, wr_lo_d;
  logic              rd_hi_q, rd_hi_d;
  cl_e               cl_q, cl_d;
  logic [CNT_W-1:0]  cl_val_q, cl_val_d;
  logic              st_pend_q, st_pend_d;
  logic [BYTE_W-1:0] st_val_q, st_val_d;
  logic              ld_stb_q, ld_stb_d;
  logic [CNT_W-1:0]  ld_val_q, ld_val_d;

  // next-state for configuration, write sequencing and latches
  always_comb begin
    cfg_d     = cfg_q;
    wr_hi_d   = wr_hi_q;
    wr_lo_d   = wr_lo_q;
    cl_d      = cl_q;
    cl_val_d  = cl_val_q;
    st_pend_d = st_pend_q;
    st_val_d  = st_val_q;
    ld_stb_d  = 1'b0;
    ld_val_d  = ld_val_q;
    rd_hi_d   = rd_hi_q;

    if (cfg_we) begin
      cfg_d   = cfg_in;
      wr_hi_d = 1'b0;
      rd_hi_d = 1'b0;
    end

    if (cnt_lat && (cl_q == CL_NONE)) begin
      cl_d     = cl_e'(cfg_q.acc);
      cl_val_d = live_cnt;
    end

    if (sts_lat && !st_pend_q) begin
      st_pend_d = 1'b1;
      st_val_d  = {live_out, 1'b0, cfg_q.acc, cfg_q.mode, cfg_q.bcd};
    end

    if (dat_we) begin
      unique case (cfg_q.acc)
        ACC_LO: begin
          ld_stb_d = 1'b1;
          ld_val_d = {{BYTE_W{1'b0}}, wdata};
        end
        ACC_HI: begin
          ld_stb_d = 1'b1;
          ld_val_d = {wdata, {BYTE_W{1'b0}}};
        end
        default: begin
          if (!wr_hi_q) begin
            wr_lo_d = wdata;
            wr_hi_d = 1'b1;
          end else begin
            ld_stb_d = 1'b1;
            ld_val_d = {wdata, wr_lo_q};
            wr_hi_d  = 1'b0;
          end
        end
      endcase
    end

    if (dat_re) begin
      if (st_pend_q) begin
        st_pend_d = 1'b0;
      end else if (cl_q == CL_BOTH) begin
        cl_d = CL_HI;
      end else if (cl_q != CL_NONE) begin
        cl_d = CL_NONE;
      end else if (cfg_q.acc == ACC_WORD) begin
        rd_hi_d = !rd_hi_q;
      end
    end
  end

  // read byte selection: status, then count latch, then live count
  always_comb begin
    if (st_pend_q) begin
      rd_byte = st_val_q;
    end else if (cl_q != CL_NONE) begin
      rd_byte = (cl_q == CL_HI) ? cl_val_q[HI:BYTE_W] : cl_val_q[LO_TOP:0];
    end else begin
      unique case (cfg_q.acc)
        ACC_HI:   rd_byte = live_cnt[HI:BYTE_W];
        ACC_WORD: rd_byte = rd_hi_q ? live_cnt[HI:BYTE_W] : live_cnt[LO_TOP:0];
        default:  rd_byte = live_cnt[LO_TOP:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '{acc: ACC_WORD, mode: '0, bcd: 1'b0};
      wr_hi_q   <= 1'b0;
      wr_lo_q   <= '0;
      rd_hi_q   <= 1'b0;
      cl_q      <= CL_NONE;
      cl_val_q  <= '0;
      st_pend_q <= 1'b0;
      st_val_q  <= '0;
      ld_stb_q  <= 1'b0;
      ld_val_q  <= '0;
    end else begin
      cfg_q     <= cfg_d;
      wr_hi_q   <= wr_hi_d;
      wr_lo_q   <= wr_lo_d;
      rd_hi_q   <= rd_hi_d;
      cl_q      <= cl_d;
      cl_val_q  <= cl_val_d;
      st_pend_q <= st_pend_d;
      st_val_q  <= st_val_d;
      ld_stb_q  <= ld_stb_d;
      ld_val_q  <= ld_val_d;
    end
  end

  assign ld_stb = ld_stb_q;
  assign ld_val = ld_val_q;
  assign mode_o = cfg_q.mode;
  assign bcd_o  = cfg_q.bcd;

  // R8
  status_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_re && st_pend_q) |=> (!st_pend_q && (cl_q == $past(cl_q))));

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_lat && (cl_q != CL_NONE)) |=> $stable(cl_val_q));

  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && (cfg_q.acc == ACC_WORD) && !wr_hi_q) |=> (!ld_stb && wr_hi_q));

  // R4
  low_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && (cfg_q.acc == ACC_LO)) |=>
      (ld_stb && (ld_val[HI:BYTE_W] == '0) && (ld_val[LO_TOP:0] == $past(wdata))));

  // R12
  cfg_reseq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (!wr_hi_q && !rd_hi_q));
endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
  import tmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NCH*BYTE_W-1:0] ch_bytes,
  output logic [BYTE_W-1:0]     rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      for (int i = 0; i < NCH; i++) begin
        if (addr == ADDR_W'(i)) rdata = ch_bytes[i*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/tmr_bus_regs.sv
module tmr_bus_regs
  import tmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [BYTE_W-1:0]     bus_wdata,
  output logic [BYTE_W-1:0]     bus_rdata,
  input  logic [NCH*CNT_W-1:0]  ch_live_cnt,
  input  logic [NCH-1:0]        ch_live_out,
  output logic [NCH-1:0]        ch_load,
  output logic [NCH*CNT_W-1:0]  ch_count,
  output logic [NCH*MODE_W-1:0] ch_mode,
  output logic [NCH-1:0]        ch_bcd
);
  cfg_t                  cfg_word;
  logic [NCH-1:0]        cfg_we, cnt_lat, sts_lat, dat_we, dat_re;
  logic [NCH*BYTE_W-1:0] ch_bytes;

  tmr_ctl_decode #(.NCH(NCH)) u_dec (
    .addr     (bus_addr),
    .wr_en    (bus_wr),
    .rd_en    (bus_rd),
    .wdata    (bus_wdata),
    .cfg_word (cfg_word),
    .cfg_we   (cfg_we),
    .cnt_lat  (cnt_lat),
    .sts_lat  (sts_lat),
    .dat_we   (dat_we),
    .dat_re   (dat_re)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_chan_port u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we[i]),
      .cfg_in   (cfg_word),
      .cnt_lat  (cnt_lat[i]),
      .sts_lat  (sts_lat[i]),
      .dat_we   (dat_we[i]),
      .dat_re   (dat_re[i]),
      .wdata    (bus_wdata),
      .live_cnt (ch_live_cnt[i*CNT_W +: CNT_W]),
      .live_out (ch_live_out[i]),
      .rd_byte  (ch_bytes[i*BYTE_W +: BYTE_W]),
      .ld_stb   (ch_load[i]),
      .ld_val   (ch_count[i*CNT_W +: CNT_W]),
      .mode_o   (ch_mode[i*MODE_W +: MODE_W]),
      .bcd_o    (ch_bcd[i])
    );
  end

  tmr_rd_mux #(.NCH(NCH)) u_mux (
    .rd_en    (bus_rd),
    .addr     (bus_addr),
    .ch_bytes (ch_bytes),
    .rdata    (bus_rdata)
  );

  // R3
  one_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_load));

  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/sim_tmr_bus_regs.sv
module sim_tmr_bus_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [47:0] ch_live_cnt = '0;
  logic [2:0]  ch_live_out = '0;
  logic [2:0]  ch_load;
  logic [47:0] ch_count;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [2:0]  last_load;
  logic [47:0] last_cnt;
  logic [7:0]  rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_bus_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_live_cnt(ch_live_cnt),
    .ch_live_out(ch_live_out), .ch_load(ch_load), .ch_count(ch_count),
    .ch_mode(ch_mode), .ch_bcd(ch_bcd)
  );

  function automatic logic [7:0] ctl(int ch, int acc, int m, int b);
    return {2'(ch), 2'(acc), 3'(m), 1'(b)};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    last_load = ch_load; last_cnt = ch_count;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #(CLK_PERIOD/4);
    d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_live(input int ch, input logic [15:0] v);
    ch_live_cnt[ch*16 +: 16] = v;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state at the ports
    check("R1 load", ch_load, 0);
    check("R1 mode", ch_mode, 0);
    check("R1 bcd", ch_bcd, 0);
    check("R11 idle rdata", bus_rdata, 0);

    // R1 / R7 reset status through read-back of all channels
    ch_live_out = 3'b101;
    bus_write(2'd3, 8'b1110_1110);
    for (int ch = 0; ch < 3; ch++) begin
      bus_read(2'(ch), rd);
      check("R1 R7 reset status", rd, {ch_live_out[ch], 1'b0, 2'b11, 3'b000, 1'b0});
    end

    // R10 reset word read alternates low then high
    set_live(1, 16'h1234);
    bus_read(2'd1, rd); check("R10 word low", rd, 8'h34);
    bus_read(2'd1, rd); check("R10 word high", rd, 8'h12);

    // R2 / R7 sweep of configurations with status read-back
    for (int ch = 0; ch < 3; ch++)
      for (int acc = 1; acc < 4; acc++)
        for (int m = 0; m < 8; m++)
          for (int b = 0; b < 2; b++) begin
            ch_live_out[ch] = 1'(b ^ m);
            bus_write(2'd3, ctl(ch, acc, m, b));
            check("R2 mode", ch_mode[ch*3 +: 3], m);
            check("R2 bcd", ch_bcd[ch], b);
            bus_write(2'd3, 8'hE0 | 8'(2 << ch));
            bus_read(2'(ch), rd);
            check("R7 status", rd, {1'(b ^ m), 1'b0, 2'(acc), 3'(m), 1'(b)});
          end

    // R3 / R4 / R5 write sweep
    for (int ch = 0; ch < 3; ch++)
      for (int acc = 1; acc < 4; acc++) begin
        bus_write(2'd3, ctl(ch, acc, 2, 0));
        for (int v = 0; v < 16; v++) begin
          logic [7:0] bv;
          bv = 8'(v * 17);
          if (acc == 1) begin
            bus_write(2'(ch), bv);
            check("R3 R4 lo strobe", last_load, 1 << ch);
            check("R4 lo value", last_cnt[ch*16 +: 16], {8'h00, bv});
          end else if (acc == 2) begin
            bus_write(2'(ch), bv);
            check("R3 R4 hi strobe", last_load, 1 << ch);
            check("R4 hi value", last_cnt[ch*16 +: 16], {bv, 8'h00});
          end else begin
            bus_write(2'(ch), bv);
            check("R5 first held", last_load, 0);
            bus_write(2'(ch), ~bv);
            check("R3 R5 word strobe", last_load, 1 << ch);
            check("R5 word value", last_cnt[ch*16 +: 16], {~bv, bv});
          end
        end
      end
    @(negedge clk);
    check("R3 pulse one cycle", ch_load, 0);

    // R6 count latch in word mode, config unchanged
    bus_write(2'd3, ctl(0, 3, 2, 0));
    set_live(0, 16'hBEEF);
    bus_write(2'd3, ctl(0, 0, 5, 1));
    check("R6 mode kept", ch_mode[2:0], 2);
    check("R6 bcd kept", ch_bcd[0], 0);
    set_live(0, 16'h2211);
    bus_read(2'd0, rd); check("R8 latch low", rd, 8'hEF);
    bus_read(2'd0, rd); check("R8 latch high", rd, 8'hBE);
    bus_read(2'd0, rd); check("R8 cleared live low", rd, 8'h11);
    bus_read(2'd0, rd); check("R10 live high", rd, 8'h22);

    // R6 / R8 latch in mode 1 and mode 2
    bus_write(2'd3, ctl(1, 1, 0, 0));
    set_live(1, 16'h3456);
    bus_write(2'd3, ctl(1, 0, 0, 0));
    set_live(1, 16'h7890);
    bus_read(2'd1, rd); check("R8 mode1 latch", rd, 8'h56);
    bus_read(2'd1, rd); check("R10 mode1 live", rd, 8'h90);
    bus_write(2'd3, ctl(2, 2, 0, 0));
    set_live(2, 16'hAB12);
    bus_write(2'd3, ctl(2, 0, 0, 0));
    set_live(2, 16'hCD34);
    bus_read(2'd2, rd); check("R8 mode2 latch", rd, 8'hAB);
    bus_read(2'd2, rd); check("R10 mode2 live", rd, 8'hCD);

    // R9 second count latch ignored
    set_live(0, 16'hA1B2);
    bus_write(2'd3, ctl(0, 0, 0, 0));
    set_live(0, 16'hC3D4);
    bus_write(2'd3, ctl(0, 0, 0, 0));
    bus_read(2'd0, rd); check("R9 count kept low", rd, 8'hB2);
    bus_read(2'd0, rd); check("R9 count kept high", rd, 8'hA1);

    // R9 second status latch ignored
    ch_live_out[0] = 1'b1;
    bus_write(2'd3, 8'b1110_0010);
    ch_live_out[0] = 1'b0;
    bus_write(2'd3, 8'b1110_0010);
    bus_read(2'd0, rd); check("R9 status kept", rd, 8'b1011_0100);
    bus_read(2'd0, rd); check("R9 no second status", rd, 8'hD4);
    bus_read(2'd0, rd);

    // R7 / R8 combined read-back on all channels
    for (int ch = 0; ch < 3; ch++) begin
      bus_write(2'd3, ctl(ch, 3, 3, 0));
      set_live(ch, 16'h1020 + 16'(ch * 16'h0101));
    end
    ch_live_out = 3'b110;
    bus_write(2'd3, 8'b1100_1110);
    ch_live_out = 3'b001;
    for (int ch = 0; ch < 3; ch++) set_live(ch, 16'hFFFF);
    for (int ch = 0; ch < 3; ch++) begin
      logic [15:0] exp;
      exp = 16'h1020 + 16'(ch * 16'h0101);
      bus_read(2'(ch), rd);
      check("R8 status first", rd, {(ch != 0) ? 1'b1 : 1'b0, 1'b0, 2'b11, 3'b011, 1'b0});
      bus_read(2'(ch), rd); check("R7 R8 rb count low", rd, exp[7:0]);
      bus_read(2'(ch), rd); check("R7 R8 rb count high", rd, exp[15:8]);
      bus_read(2'(ch), rd); check("R8 rb cleared", rd, 8'hFF);
      bus_read(2'(ch), rd);
    end

    // R7 read-back with count only, status not latched
    bus_write(2'd3, ctl(2, 2, 1, 0));
    set_live(2, 16'h5A00);
    bus_write(2'd3, 8'b1101_1000);
    set_live(2, 16'h6600);
    bus_read(2'd2, rd); check("R7 count only", rd, 8'h5A);
    bus_read(2'd2, rd); check("R7 no status", rd, 8'h66);

    // R11 address 3 read is zero and leaves the word sequence alone
    bus_write(2'd3, ctl(1, 3, 0, 0));
    set_live(1, 16'h4321);
    bus_read(2'd1, rd); check("R11 pre low", rd, 8'h21);
    bus_read(2'd3, rd); check("R11 ctl read zero", rd, 0);
    bus_read(2'd1, rd); check("R11 sequence kept", rd, 8'h43);

    // R12 control word restarts write and read sequencing
    bus_write(2'd3, ctl(0, 3, 0, 0));
    bus_write(2'd0, 8'h11);
    check("R12 first held", last_load, 0);
    bus_write(2'd3, ctl(0, 3, 0, 0));
    bus_write(2'd0, 8'h22);
    check("R12 restarted low", last_load, 0);
    bus_write(2'd0, 8'h33);
    check("R12 load", last_load, 3'b001);
    check("R12 value", last_cnt[15:0], 16'h3322);
    set_live(0, 16'h9988);
    bus_read(2'd0, rd); check("R12 read low", rd, 8'h88);
    bus_write(2'd3, ctl(0, 3, 0, 0));
    bus_read(2'd0, rd); check("R12 read restarted", rd, 8'h88);

    finish_run();
  end
endmodule